// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block picks the sampling phase for a high-speed card interface after a tuning sweep. The sweep probes each of N delay taps twice, so it delivers 2N pass/fail bits: bit i is the first probe of tap i and bit i+N the second probe of the same tap. On a start pulse the block captures those bits. It marks a tap good only when both of its probes passed. It then walks the doubled, merged vector one bit per clock, looking for the longest unbroken run of good bits, and returns the tap at the centre of that run, folded back into the range 0..N-1.

A run shorter than the minimum width gives a failure indication and leaves the applied tap as it was. A successful selection turns on automatic retuning. While that is on, an external phase-drift detector can raise a retune error, which software clears with a clear strobe. A mode input selects the reduced double-data-rate tap set. In that mode the applied tap is the selected tap halved.

Top module: `tap_window_sel`

## Requirements
- R1: A tap counts as good only when both of its result bits (bit i and bit i+N, i < N) are 1. A 0 in either bit makes both merged positions i and i+N bad.
- R2: The search covers merged positions 0 to 2N-1 in order. A run replaces the best run found so far only when it is strictly longer, so among equal-length runs the earliest one wins.
- R3: A run that is still open at position 2N-1 is compared against the best run like any closed run.
- R4: If the best run is shorter than MIN_RUN (default 3), `no_window` is 1 at completion, `tap` keeps its previous value and `retune_en` stays 0.
- R5: On success the selected tap is ((first + last) / 2) mod N, where first and last are the merged positions bounding the best run, and `no_window` is 0.
- R6: When `ddr_mode` is 1 at the start pulse, the applied `tap` is the selected tap divided by 2 (integer). When it is 0, the selected tap is applied unchanged.
- R7: `done` is a single-cycle pulse, high in the 2N+1-th cycle after the clock edge that samples `start`. A `start` or a change of `results` while a selection is in progress has no effect on that selection.
- R8: `retune_en` goes to 1 together with `done` on success, and an accepted `start` clears it on the next edge.
- R9: `retune_err` sets on the edge after `retune_hit` only while `retune_en` is 1. `retune_clear` (or an accepted `start`) clears it, and clearing wins over setting in the same cycle.
- R10: After reset, `tap`, `done`, `no_window`, `retune_en` and `retune_err` are all 0.
- R11: A `tap_count` of 0 or greater than MAX_TAPS is treated as MAX_TAPS. Any other value is used as N directly, including values that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection on the captured results (ignored while busy) |
| results | input | 2*MAX_TAPS | Sweep results: bit i first probe of tap i, bit i+N second probe |
| tap_count | input | $clog2(MAX_TAPS+1) | Number of taps N for this sweep |
| ddr_mode | input | 1 | Reduced double-data-rate tap set: apply the selected tap halved |
| retune_hit | input | 1 | Drift detected by the sampling-phase monitor |
| retune_clear | input | 1 | Clear strobe for the retune error |
| tap | output | $clog2(MAX_TAPS) | Applied sampling tap |
| done | output | 1 | One-cycle completion pulse |
| no_window | output | 1 | Last selection found no run of MIN_RUN or more good taps |
| retune_en | output | 1 | Automatic retuning enabled |
| retune_err | output | 1 | Retune error, reported only while retuning is enabled |

## Verification
A corrupted run counter or best-run register shows up only at the next `done`. It appears as a wrong `tap` or a spurious `no_window`, exactly 2N+1 cycles after the start edge. So each sweep pattern is built so that its correct tap differs from the tap a broken tie rule, a missing end-of-vector check or an unmerged vector would give. A wrong sequencer state shows up as `done` arriving at a different cycle or more than once, and every sweep checks this. The retune flag's enable gating and clear priority show at `retune_err` one edge after the stimulus.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_FIN  = 2'd2
   } tws_state_e;
endpackage

// File: rtl/tws_merge.sv
// Folds the two sweep passes together: a position is good only if the
// probe at the same tap in the other pass also passed.
module tws_merge #(
   parameter int MAX_TAPS = 8,
   parameter int CNT_W    = $clog2(MAX_TAPS + 1)
) (
   input  logic [2*MAX_TAPS-1:0] raw,
   input  logic [CNT_W-1:0]      n,
   output logic [2*MAX_TAPS-1:0] good
);
   localparam int VW = 2 * MAX_TAPS;
   localparam int PW = $clog2(VW);
   localparam int PX = PW + 1;

   logic [PX-1:0] nx;
   assign nx = {{(PX-CNT_W){1'b0}}, n};

   for (genvar j = 0; j < VW; j++) begin : g_pos
      logic [PX-1:0] jx, px;
      always_comb begin
         jx = PX'(j);
         px = (jx < nx) ? (jx + nx) : (jx - nx);
         if (jx < (nx << 1))
            good[j] = raw[j] & raw[px[PW-1:0]];
         else
            good[j] = 1'b0;
      end
   end
endmodule

// File: rtl/tws_scan.sv
// Run tracker: one merged bit per step, keeps the earliest longest run.
module tws_scan #(
   parameter int IDX_W = 4,
   parameter int LEN_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             bit_in,
   input  logic [IDX_W-1:0] idx,
   output logic [LEN_W-1:0] run_len,
   output logic [LEN_W-1:0] best_len,
   output logic [LEN_W-1:0] best_first,
   output logic [LEN_W-1:0] best_last
);
   logic [LEN_W-1:0] idx_x;
   assign idx_x = {{(LEN_W-IDX_W){1'b0}}, idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len    <= '0;
         best_len   <= '0;
         best_first <= '0;
         best_last  <= '0;
      end else if (clear) begin
         run_len    <= '0;
         best_len   <= '0;
         best_first <= '0;
         best_last  <= '0;
      end else if (step) begin
         if (bit_in) begin
            run_len <= run_len + 1'b1;
         end else begin
            if (run_len > best_len) begin
               best_len   <= run_len;
               best_first <= idx_x - run_len;
               best_last  <= idx_x - 1'b1;
            end
            run_len <= '0;
         end
      end
   end
endmodule

// File: rtl/tws_retune.sv
// Auto-retune enable and the drift error flag it gates.
module tws_retune (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_set,
   input  logic enable_clr,
   input  logic hit,
   input  logic clear,
   output logic en,
   output logic err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         err <= 1'b0;
      end else begin
         if (enable_clr)      en <= 1'b0;
         else if (enable_set) en <= 1'b1;

         if (enable_clr || clear) err <= 1'b0;
         else if (hit && en)      err <= 1'b1;
      end
   end
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel #(
   parameter int MAX_TAPS   = 8,
   parameter int MIN_RUN    = 3,
   parameter bit DDR_HALVE  = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [2*MAX_TAPS-1:0]           results,
   input  logic [$clog2(MAX_TAPS+1)-1:0]   tap_count,
   input  logic                            ddr_mode,
   input  logic                            retune_hit,
   input  logic                            retune_clear,
   output logic [$clog2(MAX_TAPS)-1:0]     tap,
   output logic                            done,
   output logic                            no_window,
   output logic                            retune_en,
   output logic                            retune_err
);
   import tws_pkg::*;

   localparam int VW    = 2 * MAX_TAPS;
   localparam int IDX_W = $clog2(VW);
   localparam int LEN_W = IDX_W + 1;
   localparam int CNT_W = $clog2(MAX_TAPS + 1);
   localparam int TAP_W = $clog2(MAX_TAPS);

   if (MAX_TAPS < 2) begin : g_bad_taps
      $error("tap_window_sel: MAX_TAPS must be at least 2");
   end
   if (MIN_RUN < 1 || MIN_RUN > VW) begin : g_bad_min
      $error("tap_window_sel: MIN_RUN must lie in 1..2*MAX_TAPS");
   end

   tws_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] n_reg;
   logic             ddr_reg;
   logic [VW-1:0]    vec;
   logic [CNT_W-1:0] n_eff;
   logic [VW-1:0]    merged;
   logic             accept, last_pos, win_ok;
   logic [LEN_W-1:0] twon, run_len, best_len, best_first, best_last;
   logic [LEN_W-1:0] c_len, c_first, c_last, mid, n_l, sel;
   logic [LEN_W:0]   sum;
   logic [TAP_W-1:0] sel_tap, tap_apply;

   // Out-of-range counts fall back to the full tap set.
   always_comb begin
      if (tap_count == '0 || tap_count > CNT_W'(MAX_TAPS))
         n_eff = CNT_W'(MAX_TAPS);
      else
         n_eff = tap_count;
   end

   tws_merge #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W)) u_merge (
      .raw  (results),
      .n    (n_eff),
      .good (merged)
   );

   assign accept   = (state == ST_IDLE) && start;
   assign twon     = LEN_W'({n_reg, 1'b0});
   assign last_pos = ({1'b0, idx} == (twon - 1'b1));

   tws_scan #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .step       (state == ST_SCAN),
      .bit_in     (vec[idx]),
      .idx        (idx),
      .run_len    (run_len),
      .best_len   (best_len),
      .best_first (best_first),
      .best_last  (best_last)
   );

   // Final candidate: a run still open at the end competes too.
   always_comb begin
      if (run_len > best_len) begin
         c_len   = run_len;
         c_first = twon - run_len;
         c_last  = twon - 1'b1;
      end else begin
         c_len   = best_len;
         c_first = best_first;
         c_last  = best_last;
      end
      sum     = {1'b0, c_first} + {1'b0, c_last};
      mid     = sum[LEN_W:1];
      n_l     = LEN_W'(n_reg);
      sel     = (mid >= n_l) ? (mid - n_l) : mid;
      sel_tap = TAP_W'(sel);
      win_ok  = (c_len >= LEN_W'(MIN_RUN));
   end

   if (DDR_HALVE) begin : g_ddr_half
      assign tap_apply = ddr_reg ? (sel_tap >> 1) : sel_tap;
   end else begin : g_ddr_full
      logic unused_ddr;
      assign unused_ddr = ddr_reg;
      assign tap_apply  = sel_tap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         n_reg     <= '0;
         ddr_reg   <= 1'b0;
         vec       <= '0;
         done      <= 1'b0;
         no_window <= 1'b0;
         tap       <= '0;
      end else begin
         done <= (state == ST_FIN);
         case (state)
            ST_IDLE: begin
               if (start) begin
                  vec     <= merged;
                  n_reg   <= n_eff;
                  ddr_reg <= ddr_mode;
                  idx     <= '0;
                  state   <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               idx <= idx + 1'b1;
               if (last_pos) state <= ST_FIN;
            end
            ST_FIN: begin
               no_window <= !win_ok;
               if (win_ok) tap <= tap_apply;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   tws_retune u_retune (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_set ((state == ST_FIN) && win_ok),
      .enable_clr (accept),
      .hit        (retune_hit),
      .clear      (retune_clear),
      .en         (retune_en),
      .err        (retune_err)
   );
endmodule

// File: rtl/tap_window_sel_chk.sv
module tap_window_sel_chk #(
   parameter int TAP_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             no_window,
   input logic             retune_en,
   input logic             retune_err,
   input logic             retune_clear,
   input logic [TAP_W-1:0] tap
);
   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: a failed search leaves the tap alone and retuning off
   a_r4_tap_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_window) |-> (tap == $past(tap)));
   a_r4_no_retune: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_window) |-> !retune_en);

   // R8: a good window turns retuning on
   a_r8_enable_on_success: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_window) |-> retune_en);

   // R9: error only while enabled, and a clear wins
   a_r9_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      retune_err |-> retune_en);
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      retune_clear |=> !retune_err);
endmodule

bind tap_window_sel tap_window_sel_chk #(.TAP_W(TAP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .done         (done),
   .no_window    (no_window),
   .retune_en    (retune_en),
   .retune_err   (retune_err),
   .retune_clear (retune_clear),
   .tap          (tap)
);

// File: tb/tb_tap_window_sel.sv
`timescale 1ns/1ps
module tb_tap_window_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] results = '0;
   logic [3:0]  tap_count = 4'd8;
   logic        ddr_mode = 1'b0;
   logic        retune_hit = 1'b0;
   logic        retune_clear = 1'b0;
   logic [2:0]  tap;
   logic        done, no_window, retune_en, retune_err;

   int checks = 0;
   int errors = 0;
   int model_tap = 0;
   bit finished = 1'b0;

   typedef struct {
      int    tap;
      bit    err;
      string req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   tap_window_sel #(.MAX_TAPS(8), .MIN_RUN(3), .DDR_HALVE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .results(results),
      .tap_count(tap_count), .ddr_mode(ddr_mode), .retune_hit(retune_hit),
      .retune_clear(retune_clear), .tap(tap), .done(done),
      .no_window(no_window), .retune_en(retune_en), .retune_err(retune_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Reference selection written from the requirements.
   function automatic void model(input logic [15:0] r, input int n_in, input bit ddr,
                                 output int etap, output bit eerr);
      int n, run, best, bf, bl, p, t;
      bit g [16];
      n = (n_in == 0 || n_in > 8) ? 8 : n_in;
      for (int j = 0; j < 2*n; j++) begin
         p = (j < n) ? j + n : j - n;
         g[j] = r[j] & r[p];
      end
      run = 0; best = 0; bf = 0; bl = 0;
      for (int i = 0; i < 2*n; i++) begin
         if (g[i]) run++;
         else begin
            if (run > best) begin best = run; bf = i - run; bl = i - 1; end
            run = 0;
         end
      end
      if (run > best) begin best = run; bf = 2*n - run; bl = 2*n - 1; end
      if (best >= 3) begin
         t = ((bf + bl) / 2) % n;
         if (ddr) t = t / 2;
         model_tap = t;
         eerr = 1'b0;
      end else begin
         eerr = 1'b1;
      end
      etap = model_tap;
   endfunction

   // Driver: push the expectation, pulse start, time the completion.
   task automatic run_case(input logic [15:0] r, input int n, input bit ddr,
                           input string req, input bit poke);
      int   et, neff, seen;
      bit   ee;
      exp_t e;
      model(r, n, ddr, et, ee);
      e.tap = et; e.err = ee; e.req = req;
      sb.push_back(e);
      neff = (n == 0 || n > 8) ? 8 : n;
      results = r; tap_count = 4'(n); ddr_mode = ddr;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(retune_en == 1'b0, "R8", "retune_en after start", int'(retune_en), 0);
      seen = 0;
      for (int k = 1; k <= 2*neff + 4; k++) begin
         if (poke && k == 3) begin
            start = 1'b1; results = ~r; ddr_mode = ~ddr;
         end
         @(posedge clk);
         @(negedge clk);
         if (poke && k == 3) start = 1'b0;
         if (done) begin
            seen++;
            check(k == 2*neff + 1, "R7", "done latency", k, 2*neff + 1);
         end
      end
      check(seen == 1, "R7", "done pulse count", seen, 1);
   endtask

   // Monitor: compare each completion against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(tap) == e.tap, e.req, "tap", int'(tap), e.tap);
            check(no_window == e.err, e.req, "no_window", int'(no_window), int'(e.err));
            check(retune_en == !e.err, "R8", "retune_en at done", int'(retune_en), int'(!e.err));
         end
      end
   end

   task automatic pulse(input bit hit, input bit clr);
      retune_hit = hit; retune_clear = clr;
      @(posedge clk);
      @(negedge clk);
      retune_hit = 1'b0; retune_clear = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset values
      check(tap == 3'd0 && done == 1'b0, "R10", "tap/done after reset", int'(tap), 0);
      check(no_window == 1'b0 && retune_en == 1'b0 && retune_err == 1'b0,
            "R10", "flags after reset", int'({no_window, retune_en, retune_err}), 0);

      run_case(16'hFFFF, 8, 1'b0, "R3", 1'b0);   // open run to the end -> 7
      run_case(16'h7777, 8, 1'b0, "R2", 1'b0);   // equal runs, earliest -> 1
      run_case(16'hDFFF, 8, 1'b0, "R1", 1'b0);   // second-pass fail at tap 5 -> 1
      run_case(16'hC3C3, 8, 1'b0, "R5", 1'b0);   // window wraps the tap range -> 7

      // R9: error flag behaviour while retuning is enabled
      pulse(1'b1, 1'b0);
      check(retune_err == 1'b1, "R9", "err after hit", int'(retune_err), 1);
      pulse(1'b0, 1'b1);
      check(retune_err == 1'b0, "R9", "err after clear", int'(retune_err), 0);
      pulse(1'b1, 1'b0);
      pulse(1'b1, 1'b1);
      check(retune_err == 1'b0, "R9", "clear wins over hit", int'(retune_err), 0);

      run_case(16'h0C0C, 8, 1'b0, "R4", 1'b0);   // only 2 good taps -> hold 7
      pulse(1'b1, 1'b0);
      check(retune_err == 1'b0, "R9", "hit ignored while disabled", int'(retune_err), 0);
      check(int'(tap) == 7, "R4", "tap held after failure", int'(tap), 7);

      run_case(16'h55EE, 4, 1'b1, "R6", 1'b0);   // N=4, DDR halves 2 -> 1
      run_case(16'h55EE, 4, 1'b0, "R6", 1'b0);   // N=4 full tap -> 2
      run_case(16'h03DF, 5, 1'b0, "R11", 1'b0);  // N=5 -> 2
      run_case(16'hDFFF, 0, 1'b0, "R11", 1'b0);  // count 0 treated as 8 -> 1
      run_case(16'hC3C3, 12, 1'b0, "R11", 1'b0); // count 12 treated as 8 -> 7
      run_case(16'h7777, 8, 1'b0, "R7", 1'b1);   // start while busy ignored -> 1

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
      summary();
   end
endmodule